// File: doc/BRIEF.md
# Deep Sleep Wake Sequencer

This block stops the device's clocks and turns off the oscillator when a sleep request line falls, and brings them back when the line rises again. Before the line has any effect, software must arm the sequencer through a small synchronous register port.

The request can come from one of two sources, picked by a plain select pin. One is a pin driven from outside the device. The other is a wake line from an on-chip real-time clock, which gives a timed automatic wake. Whichever source is selected passes through a synchronizer chain. After that, sleep is entered only on a high-to-low transition that arrives while the block is armed.

On wake the oscillator enable returns at once. The clock enable is held off for a programmed stabilization count. After that the clocks are released and a completion flag is raised, which software can poll. Any register write clears that flag, so setting or clearing the arm bit both clear it. The block has no streaming data path, so every pin is a plain level signal.

Top module: `deep_sleep_seq`

## Requirements
- R1: After reset, `osc_en` and `clk_en` are 1 and `reg_rdata` reads all zero.
- R2: A falling request seen while the arm bit is 0 is ignored: `osc_en` and `clk_en` stay 1.
- R3: Suppose the arm bit is 1 and the selected request falls from 1 to 0. Then, three rising clock edges later, `osc_en` and `clk_en` are both 0, and they stay 0 while the request stays low.
- R4: `req_src_sel` = 0 selects `ext_sleep_n` and `req_src_sel` = 1 selects `rtc_sleep_n`. The request line that is not selected has no effect.
- R5: Once the request returns high during sleep, `osc_en` goes to 1 three edges later. `clk_en` then stays 0 for exactly COUNT+1 cycles before it goes to 1.
- R6: The completion flag, `reg_rdata[1]`, becomes 1 in the same cycle that `clk_en` is released, and it stays 1 until the next register write.
- R7: A write with `reg_wdata[0]` = 1 sets the arm bit and clears the completion flag. `reg_wdata[CNT_W:1]` loads COUNT. The read layout is arm in bit 0, completion in bit 1 and COUNT in bits [CNT_W+1:2].
- R8: A write with `reg_wdata[0]` = 0 clears the arm bit and the completion flag. A later falling request then has no effect.
- R9: A request that falls during the stabilization count is ignored: the count runs to its end and the clocks are released on schedule. A fall while the clocks are already released does not re-enter sleep.
- R10: A request that is already low when the block is armed does not cause sleep. Sleep needs a new high-to-low transition.
- R11: A COUNT of 0 releases `clk_en` on the first cycle after `osc_en` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | CNT_W+1 | Write data: arm in bit 0, COUNT above it |
| reg_rdata | output | CNT_W+2 | Read data: arm, completion, COUNT |
| req_src_sel | input | 1 | Request source: 0 external pin, 1 real-time clock |
| ext_sleep_n | input | 1 | External active-low sleep request |
| rtc_sleep_n | input | 1 | Real-time-clock active-low sleep request |
| osc_en | output | 1 | Oscillator enable |
| clk_en | output | 1 | Downstream clock enable |

## Verification
The bench builds the block with CNT_W = 8 and two synchronizer stages. The 8-bit count keeps every stabilization window short, so counts of 0, 2, 3, 5 and 20 can each run to completion many times within the cycle budget. The count of 20 leaves room for a request to fall and recover in the middle of a window. With two stages, the latency from request pin to state change is a fixed three edges, so the bench can sample entry and wake on exact cycles.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ARMED  = 3'd1,
    ST_ASLEEP = 3'd2,
    ST_WAKE   = 3'd3,
    ST_DONE   = 3'd4
  } dsw_state_e;
endpackage

// File: rtl/dsw_sync.sv
// Resettable synchronizer chain for an asynchronous active-low request.
module dsw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dsw_regs.sv
// Control/status register: arm bit, stabilization count, completion flag.
module dsw_regs #(
  parameter int CNT_W = 16,
  localparam int WD_W = CNT_W + 1,
  localparam int RD_W = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WD_W-1:0]  wdata,
  input  logic             set_done,
  output logic             arm,
  output logic [CNT_W-1:0] count,
  output logic             complete,
  output logic [RD_W-1:0]  rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm   <= 1'b0;
      count <= '0;
    end else if (wr_en) begin
      arm   <= wdata[0];
      count <= wdata[WD_W-1:1];
    end
  end

  // Completion is raised by the sequencer; any write clears it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        complete <= 1'b0;
    else if (set_done) complete <= 1'b1;
    else if (wr_en)    complete <= 1'b0;
  end

  assign rdata = {count, complete, arm};

  assert_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !set_done) |=> !complete);

  assert_arm_follows_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (arm == $past(wdata[0])));
endmodule

// File: rtl/dsw_wake_timer.sv
// Oscillator stabilization down-counter.
module dsw_wake_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (load)                cnt <= load_val;
    else if (run && cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/dsw_fsm.sv
// Sleep/wake state machine and enable decode.
module dsw_fsm
  import dsw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_s,
  input  logic arm,
  input  logic wr_en,
  input  logic expired,
  input  logic complete,
  output logic timer_load,
  output logic timer_run,
  output logic set_done,
  output logic osc_en,
  output logic clk_en
);
  dsw_state_e state, state_nx;
  logic req_prev;
  logic req_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_prev <= 1'b1;
    else        req_prev <= req_s;
  end

  assign req_fall = req_prev && !req_s;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:   if (arm) state_nx = ST_ARMED;
      ST_ARMED:  if (!arm) state_nx = ST_IDLE;
                 else if (req_fall) state_nx = ST_ASLEEP;
      ST_ASLEEP: if (req_s) state_nx = ST_WAKE;
      ST_WAKE:   if (expired) state_nx = ST_DONE;
      ST_DONE:   if (wr_en) state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign timer_load = (state == ST_ASLEEP) && req_s;
  assign timer_run  = (state == ST_WAKE);
  assign set_done   = (state == ST_WAKE) && expired;
  assign osc_en     = (state != ST_ASLEEP);
  assign clk_en     = (state == ST_IDLE) || (state == ST_ARMED) || (state == ST_DONE);

  assert_sleep_needs_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> $past(arm));

  assert_clk_needs_osc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> !clk_en);

  assert_delay_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAKE && !expired) |=> (state == ST_WAKE));

  assert_complete_with_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    complete |-> clk_en);

  assert_wake_runs_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAKE) |=> (state == ST_WAKE || state == ST_DONE));
endmodule

// File: rtl/deep_sleep_seq.sv
module deep_sleep_seq #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int WD_W = CNT_W + 1,
  localparam int RD_W = CNT_W + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr_en,
  input  logic [WD_W-1:0] reg_wdata,
  output logic [RD_W-1:0] reg_rdata,
  input  logic            req_src_sel,
  input  logic            ext_sleep_n,
  input  logic            rtc_sleep_n,
  output logic            osc_en,
  output logic            clk_en
);
  logic             req_raw;
  logic             req_s;
  logic             arm;
  logic [CNT_W-1:0] count;
  logic             complete;
  logic             set_done;
  logic             timer_load;
  logic             timer_run;
  logic             expired;

  assign req_raw = req_src_sel ? rtc_sleep_n : ext_sleep_n;

  dsw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(req_raw), .q(req_s)
  );

  dsw_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wdata(reg_wdata),
    .set_done(set_done), .arm(arm), .count(count), .complete(complete),
    .rdata(reg_rdata)
  );

  dsw_wake_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(timer_load), .load_val(count),
    .run(timer_run), .expired(expired)
  );

  dsw_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_s(req_s), .arm(arm), .wr_en(reg_wr_en),
    .expired(expired), .complete(complete), .timer_load(timer_load),
    .timer_run(timer_run), .set_done(set_done), .osc_en(osc_en),
    .clk_en(clk_en)
  );
endmodule

// File: tb/deep_sleep_seq_tb_top.sv
module deep_sleep_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int WATCHDOG = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr_en = 1'b0;
  logic [CW:0]   reg_wdata = '0;
  logic [CW+1:0] reg_rdata;
  logic          req_src_sel = 1'b0;
  logic          ext_sleep_n = 1'b1;
  logic          rtc_sleep_n = 1'b1;
  logic          osc_en;
  logic          clk_en;

  int checks = 0;
  int errors = 0;
  int exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  deep_sleep_seq #(.CNT_W(CW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .req_src_sel(req_src_sel), .ext_sleep_n(ext_sleep_n),
    .rtc_sleep_n(rtc_sleep_n), .osc_en(osc_en), .clk_en(clk_en)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit arm, input int cnt);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_wdata = {cnt[CW-1:0], arm};
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic wait_release();
    for (int i = 0; i < 400; i++) begin
      if (clk_en) break;
      @(negedge clk);
    end
  endtask

  // Monitor: measure osc_en rise to clk_en rise, compare with scoreboard.
  logic prev_osc = 1'b1;
  bit   waiting = 1'b0;
  int   dly = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (osc_en && !prev_osc) begin
        waiting = 1'b1;
        dly = 0;
      end else if (waiting) begin
        dly++;
        if (clk_en) begin
          int e;
          waiting = 1'b0;
          if (exp_q.size() == 0) begin
            check(1'b0, "R5 unexpected release", dly, -1);
          end else begin
            e = exp_q.pop_front();
            check(dly == e, "R5/R11 wake delay", dly, e);
            check(reg_rdata[1] == 1'b1, "R6 complete at release", reg_rdata[1], 1);
          end
        end
      end
      prev_osc = osc_en;
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1
    check(osc_en == 1'b1, "R1 osc_en", osc_en, 1);
    check(clk_en == 1'b1, "R1 clk_en", clk_en, 1);
    check(reg_rdata == '0, "R1 rdata", reg_rdata, 0);

    // R2: unarmed fall ignored
    ext_sleep_n = 1'b0;
    cyc(8);
    check(osc_en && clk_en, "R2 unarmed fall", {osc_en, clk_en}, 3);
    ext_sleep_n = 1'b1;
    cyc(4);

    // R7: arm with count 5
    wr(1'b1, 5);
    check(reg_rdata == {8'd5, 1'b0, 1'b1}, "R7 readback", reg_rdata, {8'd5, 1'b0, 1'b1});
    cyc(2);

    // R3: sleep on armed fall, exactly three edges
    exp_q.push_back(6);
    ext_sleep_n = 1'b0;
    cyc(2);
    check(osc_en == 1'b1, "R3 not yet asleep", osc_en, 1);
    cyc(1);
    check(!osc_en && !clk_en, "R3 asleep", {osc_en, clk_en}, 0);
    cyc(20);
    check(!osc_en && !clk_en, "R3 stays asleep", {osc_en, clk_en}, 0);
    ext_sleep_n = 1'b1;
    cyc(3);
    check(osc_en == 1'b1 && clk_en == 1'b0, "R5 osc back", {osc_en, clk_en}, 2);
    wait_release();
    cyc(3);
    check(reg_rdata[1] == 1'b1, "R6 complete held", reg_rdata[1], 1);

    // R7 clear on arm write; R11 count zero
    wr(1'b1, 0);
    check(reg_rdata[1] == 1'b0, "R7 arm clears complete", reg_rdata[1], 0);
    cyc(2);
    exp_q.push_back(1);
    ext_sleep_n = 1'b0;
    cyc(4);
    check(!osc_en, "R11 asleep", osc_en, 0);
    ext_sleep_n = 1'b1;
    cyc(4);
    wait_release();
    cyc(2);

    // R8: disarm clears complete, later fall ignored
    wr(1'b0, 0);
    check(reg_rdata[1:0] == 2'b00, "R8 disarm clears", reg_rdata[1:0], 0);
    cyc(2);
    ext_sleep_n = 1'b0;
    cyc(8);
    check(osc_en && clk_en, "R8 fall ignored", {osc_en, clk_en}, 3);
    ext_sleep_n = 1'b1;
    cyc(4);

    // R4: source select
    req_src_sel = 1'b1;
    wr(1'b1, 3);
    cyc(2);
    ext_sleep_n = 1'b0;
    cyc(8);
    check(osc_en == 1'b1, "R4 unselected ext ignored", osc_en, 1);
    ext_sleep_n = 1'b1;
    cyc(2);
    exp_q.push_back(4);
    rtc_sleep_n = 1'b0;
    cyc(4);
    check(!osc_en, "R4 rtc sleeps", osc_en, 0);
    rtc_sleep_n = 1'b1;
    cyc(4);
    wait_release();
    cyc(2);

    // R9: fall during stabilization ignored
    req_src_sel = 1'b0;
    wr(1'b1, 20);
    cyc(2);
    exp_q.push_back(21);
    ext_sleep_n = 1'b0;
    cyc(4);
    check(!osc_en, "R9 asleep", osc_en, 0);
    ext_sleep_n = 1'b1;
    cyc(8);
    ext_sleep_n = 1'b0;
    cyc(3);
    ext_sleep_n = 1'b1;
    cyc(2);
    check(osc_en == 1'b1, "R9 osc stays on", osc_en, 1);
    wait_release();
    cyc(2);
    ext_sleep_n = 1'b0;
    cyc(8);
    check(clk_en && reg_rdata[1], "R9 no re-entry when done", {clk_en, reg_rdata[1]}, 3);

    // R10: already-low line at arm time
    wr(1'b1, 2);
    cyc(10);
    check(osc_en == 1'b1, "R10 level not edge", osc_en, 1);
    ext_sleep_n = 1'b1;
    cyc(4);
    exp_q.push_back(3);
    ext_sleep_n = 1'b0;
    cyc(4);
    check(!osc_en, "R10 new edge sleeps", osc_en, 0);
    ext_sleep_n = 1'b1;
    cyc(4);
    wait_release();
    cyc(4);

    check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule